// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block sends 32-bit ARINC 429 words as a return-to-zero bipolar bit stream. The stream leaves on two digital outputs, one for the ONE level and one for the ZERO level, and each output feeds one input of an external line driver. The host loads a word with two 16-bit writes into a holding register. It selects odd or even parity for the last bit and picks one of two bit rates. Then it pulses a start strobe. The transmitter latches the word, adds the parity bit, sends line bit 1 first and bit 32 last, and follows every word with a null gap. A busy flag tells the host when the next start will be accepted.

A self-test input selects what reaches the receive-side outputs. They carry either the transmitter's own two serial outputs or the external line inputs, so a receiver can check the transmit path without a line attached.

Top module: `bipolar_word_tx`

## Requirements
- R1: Line bit 1 (held in holding-register position 0) goes out first and line bit 32 goes out last. There is one bit time per line bit.
- R2: Bit 32 is parity computed over line bits 1..31 when start is accepted. With `par_even`=0 the 32 bits carry an odd number of ones. With `par_even`=1 they carry an even number. Whatever the host wrote for bit 32 (first-write bus bit 8) has no effect.
- R3: One bit time is 10 clock cycles (two halves of 5) when `slow_rate`=0 and 80 cycles (two halves of 40) when `slow_rate`=1. The rate is sampled when start is accepted.
- R4: In the first half of a bit time `tx_hi`=1 for a ONE, or `tx_lo`=1 for a ZERO. In the second half both are 0. The two outputs are never 1 together.
- R5: After bit 32, four bit times of null (both outputs 0) follow while `busy` stays 1. `busy` is 1 for exactly 72 half-bit periods from the edge that accepts start.
- R6: A start while `busy`=1 is ignored: the word in flight, its timing and its parity go on unchanged.
- R7: A first-half write maps `wr_data` bits 15..11 to line bits 13..9, bit 10 to line bit 31, bit 9 to line bit 30, and bits 7..0 to line bits 1..8 (bit 7 is line bit 1). Bit 8 is ignored.
- R8: A second-half write maps `wr_data` bit k to line bit 14+k, for k = 0..15.
- R9: With `selftest_n`=0, `rx_hi`/`rx_lo` follow `tx_hi`/`tx_lo`. With `selftest_n`=1 they follow `line_in_hi`/`line_in_lo`.
- R10: After reset, `busy`, `tx_hi` and `tx_lo` are 0 and the holding register is all zero. A start with no write then sends 31 zero bits and parity 1 in odd mode.
- R11: Writes during a transmission change only the holding register. They reach the line in the next word and not in the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_first | input | 1 | Write strobe for the first half-word (R7 mapping) |
| wr_second | input | 1 | Write strobe for the second half-word (R8 mapping) |
| wr_data | input | 16 | Host write data |
| start | input | 1 | Start-of-word strobe |
| par_even | input | 1 | 0 = odd parity, 1 = even parity in bit 32 |
| slow_rate | input | 1 | 0 = clock/10 bit rate, 1 = clock/80 |
| selftest_n | input | 1 | Active-low self-test (loopback) enable |
| line_in_hi | input | 1 | External receive ONE input |
| line_in_lo | input | 1 | External receive ZERO input |
| tx_hi | output | 1 | Serial ONE drive |
| tx_lo | output | 1 | Serial ZERO drive |
| busy | output | 1 | Word or gap in progress |
| rx_hi | output | 1 | Receiver-side ONE (loopback or line) |
| rx_lo | output | 1 | Receiver-side ZERO (loopback or line) |

## Verification
Assertions check the following on every cycle:
- the two drive outputs are never high together;
- the outputs are null when busy falls;
- a start while busy leaves the shift register and bit count alone;
- the freshly loaded word always has the selected parity;
- the half-bit counter restarts from zero;
- each host write lands in the register positions its mapping names.

Only the bench's scenarios can show the rest:
- the full bit order on the line, the bus-to-line mapping and the exact width of each half bit at both rates;
- that the 72-half-bit busy length holds;
- that writes made mid-word reach the next word but not the current one;
- the loopback routing.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

  localparam int BODY_W = 31;

  typedef logic [BODY_W-1:0] body_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DATA = 2'd1,
    S_GAP  = 2'd2
  } tx_state_t;

  // First half-word: bus 7..0 -> line 1..8, bus 15..11 -> line 13..9,
  // bus 10 -> line 31, bus 9 -> line 30; bus 8 has no destination.
  function automatic body_t merge_first(body_t cur, logic [15:0] d);
    body_t r = cur;
    for (int j = 0; j < 8; j++) r[j] = d[7-j];
    for (int j = 0; j < 5; j++) r[8+j] = d[11+j];
    r[29] = d[9];
    r[30] = d[10];
    return r;
  endfunction

  // Second half-word: bus k -> line 14+k (register index 13+k).
  function automatic body_t merge_second(body_t cur, logic [15:0] d);
    body_t r = cur;
    for (int j = 0; j < 16; j++) r[13+j] = d[j];
    return r;
  endfunction

  // Bit that completes the word to the requested parity.
  function automatic logic parity_fill(body_t b, logic even);
    logic x;
    x = ^b;
    return even ? x : ~x;
  endfunction

endpackage

// File: rtl/bwt_hold_reg.sv
module bwt_hold_reg
  import bwt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_first,
  input  logic        wr_second,
  input  logic [15:0] wr_data,
  output body_t       body
);

  body_t nxt;

  always_comb begin
    nxt = body;
    if (wr_first)  nxt = merge_first(nxt, wr_data);
    if (wr_second) nxt = merge_second(nxt, wr_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) body <= '0;
    else        body <= nxt;
  end

  // Host copy of bit 32 is discarded: parity is generated at load.
  logic host_b32_unused;
  assign host_b32_unused = wr_data[8];

  // R7: first write lands line bit 1 and line bit 31
  p_first_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_first |=> (body[0] == $past(wr_data[7])) && (body[30] == $past(wr_data[10])));

  // R8: second write lands line bits 14 and 29
  p_second_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_second |=> (body[13] == $past(wr_data[0])) && (body[28] == $past(wr_data[15])));

endmodule

// File: rtl/bwt_half_timer.sv
module bwt_half_timer #(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic half_tick
);

  localparam int HALF_F = FAST_DIV / 2;
  localparam int HALF_S = SLOW_DIV / 2;
  localparam int HALF_MAX = (HALF_S > HALF_F) ? HALF_S : HALF_F;
  localparam int CW = $clog2(HALF_MAX + 1);
  localparam logic [CW-1:0] LAST_F = CW'(HALF_F - 1);
  localparam logic [CW-1:0] LAST_S = CW'(HALF_S - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last      = slow ? LAST_S : LAST_F;
  assign half_tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || half_tick) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // R3: every word starts with a full first half
  p_fresh_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));

  // R3: halves are at least two cycles long
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick);

endmodule

// File: rtl/bwt_sequencer.sv
module bwt_sequencer
  import bwt_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int GAP_BITS  = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  par_even,
  input  logic  slow_rate,
  input  body_t body,
  input  logic  half_tick,
  output logic  busy,
  output logic  rate_q,
  output logic  tx_hi,
  output logic  tx_lo
);

  localparam int BCW = $clog2(WORD_BITS + GAP_BITS + 1);
  localparam logic [BCW-1:0] LAST_DATA = BCW'(WORD_BITS - 1);
  localparam logic [BCW-1:0] LAST_GAP  = BCW'(GAP_BITS - 1);

  tx_state_t              state;
  logic                   phase;   // 0 = driven half, 1 = null half
  logic [BCW-1:0]         bitcnt;
  logic [WORD_BITS-1:0]   sh;
  logic                   accept;
  logic                   bit_end;

  assign busy    = (state != S_IDLE);
  assign accept  = (state == S_IDLE) && start;
  assign bit_end = half_tick && phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      phase  <= 1'b0;
      bitcnt <= '0;
      sh     <= '0;
      rate_q <= 1'b0;
    end else if (accept) begin
      state  <= S_DATA;
      phase  <= 1'b0;
      bitcnt <= '0;
      sh     <= {parity_fill(body, par_even), body};
      rate_q <= slow_rate;
    end else if (half_tick) begin
      phase <= ~phase;
      if (bit_end) begin
        unique case (state)
          S_DATA: begin
            sh <= sh >> 1;
            if (bitcnt == LAST_DATA) begin
              state  <= S_GAP;
              bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          S_GAP: begin
            if (bitcnt == LAST_GAP) begin
              state  <= S_IDLE;
              bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign tx_hi = (state == S_DATA) && !phase &&  sh[0];
  assign tx_lo = (state == S_DATA) && !phase && !sh[0];

  // R2: loaded word carries the requested parity
  p_parity_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ((^sh) == !$past(par_even)));

  // R6: start during a word disturbs neither data nor position
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !half_tick) |=> ($stable(sh) && $stable(bitcnt) && $stable(rate_q)));

  // R5: an accepted start always begins at line bit 1
  p_start_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == S_DATA) && !phase && (bitcnt == '0));

endmodule

// File: rtl/bwt_loopback.sv
module bwt_loopback #(
  parameter int LANES = 2
) (
  input  logic             selftest_n,
  input  logic [LANES-1:0] tx_lane,
  input  logic [LANES-1:0] line_lane,
  output logic [LANES-1:0] rx_lane
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rx_lane[i] = selftest_n ? line_lane[i] : tx_lane[i];
  end

endmodule

// File: rtl/bipolar_word_tx.sv
module bipolar_word_tx #(
  parameter int FAST_DIV  = 10,
  parameter int SLOW_DIV  = 80,
  parameter int GAP_BITS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_first,
  input  logic        wr_second,
  input  logic [15:0] wr_data,
  input  logic        start,
  input  logic        par_even,
  input  logic        slow_rate,
  input  logic        selftest_n,
  input  logic        line_in_hi,
  input  logic        line_in_lo,
  output logic        tx_hi,
  output logic        tx_lo,
  output logic        busy,
  output logic        rx_hi,
  output logic        rx_lo
);

  import bwt_pkg::*;

  localparam int WORD_BITS = BODY_W + 1;

  body_t body;
  logic  half_tick;
  logic  rate_q;
  logic [1:0] rx_pair;

  bwt_hold_reg u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_first  (wr_first),
    .wr_second (wr_second),
    .wr_data   (wr_data),
    .body      (body)
  );

  bwt_half_timer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .slow      (rate_q),
    .half_tick (half_tick)
  );

  bwt_sequencer #(.WORD_BITS(WORD_BITS), .GAP_BITS(GAP_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .par_even  (par_even),
    .slow_rate (slow_rate),
    .body      (body),
    .half_tick (half_tick),
    .busy      (busy),
    .rate_q    (rate_q),
    .tx_hi     (tx_hi),
    .tx_lo     (tx_lo)
  );

  bwt_loopback #(.LANES(2)) u_loop (
    .selftest_n (selftest_n),
    .tx_lane    ({tx_lo, tx_hi}),
    .line_lane  ({line_in_lo, line_in_hi}),
    .rx_lane    (rx_pair)
  );

  assign rx_hi = rx_pair[0];
  assign rx_lo = rx_pair[1];

  // R4: the two drive levels never overlap
  p_rz_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_hi && tx_lo));

  // R5: the word ends on null
  p_gap_null_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(!tx_hi && !tx_lo));

endmodule

// File: tb/bipolar_word_tx_test.sv
`timescale 1ns/1ps
module bipolar_word_tx_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_first = 1'b0, wr_second = 1'b0;
  logic [15:0] wr_data = '0;
  logic start = 1'b0, par_even = 1'b0, slow_rate = 1'b0;
  logic selftest_n = 1'b1, line_in_hi = 1'b0, line_in_lo = 1'b1;
  logic tx_hi, tx_lo, busy, rx_hi, rx_lo;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bipolar_word_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_first(wr_first), .wr_second(wr_second),
    .wr_data(wr_data), .start(start), .par_even(par_even), .slow_rate(slow_rate),
    .selftest_n(selftest_n), .line_in_hi(line_in_hi), .line_in_lo(line_in_lo),
    .tx_hi(tx_hi), .tx_lo(tx_lo), .busy(busy), .rx_hi(rx_hi), .rx_lo(rx_lo)
  );

  // {first word, second word, even parity, slow rate, selftest_n}
  localparam logic [34:0] VEC [0:5] = '{
    {16'hA5C3, 16'h1234, 1'b0, 1'b0, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1},
    {16'h0100, 16'h0000, 1'b1, 1'b0, 1'b1},
    {16'h0001, 16'h8000, 1'b1, 1'b1, 1'b1},
    {16'h5A5A, 16'h0F0F, 1'b0, 1'b1, 1'b0},
    {16'h8000, 16'h0001, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected line word, bit n = line bit n, built from the mapping tables.
  function automatic logic [32:1] expect_word(logic [15:0] a, logic [15:0] b, logic even);
    logic [32:1] w = '0;
    int ones = 0;
    for (int k = 0; k < 16; k++) begin
      int n;
      if (k <= 7)       n = 8 - k;
      else if (k == 8)  n = 0;
      else if (k == 9)  n = 30;
      else if (k == 10) n = 31;
      else              n = k - 2;
      if (n != 0) w[n] = a[k];
      w[14+k] = b[k];
    end
    for (int n = 1; n <= 31; n++) ones += int'(w[n]);
    w[32] = even ? logic'(ones % 2) : logic'(1 - (ones % 2));
    return w;
  endfunction

  task automatic run_frame(input logic [15:0] a, input logic [15:0] b, input logic even,
                           input logic slow, input logic st_n, input bit do_write,
                           input bit disturb, input string tag);
    logic [32:1] w;
    int h, e_data, e_par, e_rz, e_gap, e_busy, e_loop;
    w = expect_word(a, b, even);
    h = slow ? 40 : 5;
    e_data = 0; e_par = 0; e_rz = 0; e_gap = 0; e_busy = 0; e_loop = 0;
    selftest_n = st_n;
    if (do_write) begin
      wr_first = 1'b1; wr_data = a; @(negedge clk);
      wr_first = 1'b0; wr_second = 1'b1; wr_data = b; @(negedge clk);
      wr_second = 1'b0;
    end
    par_even = even; slow_rate = slow; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= 72 * h; c++) begin
      logic eh, el, eb;
      int half, bitn;
      half = c / h;
      bitn = half / 2 + 1;
      eh = 1'b0; el = 1'b0; eb = (c < 72 * h);
      if (half < 64 && (half % 2) == 0) begin
        eh = w[bitn]; el = !w[bitn];
      end
      if (half < 64) begin
        if ((half % 2) == 0) begin
          if (tx_hi !== eh || tx_lo !== el) begin
            if (bitn == 32) e_par++; else e_data++;
          end
        end else if (tx_hi !== 1'b0 || tx_lo !== 1'b0) e_rz++;
      end else if (tx_hi !== 1'b0 || tx_lo !== 1'b0) e_gap++;
      if (busy !== eb) e_busy++;
      if (st_n == 1'b0) begin
        if (rx_hi !== tx_hi || rx_lo !== tx_lo) e_loop++;
      end else if (rx_hi !== line_in_hi || rx_lo !== line_in_lo) e_loop++;
      if (disturb && (c == 3 * h || c == 3 * h + 1)) begin
        start = 1'b1; par_even = !even; slow_rate = !slow;
        wr_first = (c == 3 * h); wr_second = (c != 3 * h);
        wr_data = (c == 3 * h) ? ~a : ~b;
      end else begin
        start = 1'b0; par_even = even; slow_rate = slow;
        wr_first = 1'b0; wr_second = 1'b0;
      end
      @(negedge clk);
    end
    wr_first = 1'b0; wr_second = 1'b0; start = 1'b0;
    check(e_data == 0, {"R1 bit order/data ", tag}, e_data, 0);
    check(e_par == 0,  {"R2 parity bit 32 ", tag}, e_par, 0);
    check(e_rz == 0,   {"R4 null second half ", tag}, e_rz, 0);
    check(e_gap == 0,  {"R5 inter-word null gap ", tag}, e_gap, 0);
    check(e_busy == 0, {"R3 busy length at rate ", tag}, e_busy, 0);
    check(e_loop == 0, {"R9 receive routing ", tag}, e_loop, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
    check(tx_hi == 1'b0 && tx_lo == 1'b0, "R10 outputs null in reset",
          int'({tx_hi, tx_lo}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R10 idle after reset release", int'(busy), 0);

    // R10: cleared holding register gives zeros plus odd parity 1
    run_frame(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10 empty word");

    // table of vectors (R7 R8 mappings, R2 host bit 32 ignored)
    for (int i = 0; i < 6; i++) begin
      logic [34:0] v;
      v = VEC[i];
      run_frame(v[34:19], v[18:3], v[2], v[1], v[0], 1'b1, 1'b0, "R7 R8 table");
    end

    // R6 / R11: start, control changes and writes during a word
    run_frame(16'h3C96, 16'hC3A5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R6 start ignored");
    // R11: the mid-word writes make the next word
    run_frame(~16'h3C96, ~16'hC3A5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R11 next word");

    // R9: idle routing both ways
    selftest_n = 1'b1; line_in_hi = 1'b1; line_in_lo = 1'b0;
    @(negedge clk);
    check(rx_hi == 1'b1 && rx_lo == 1'b0, "R9 line inputs pass", int'({rx_hi, rx_lo}), 2);
    selftest_n = 1'b0;
    @(negedge clk);
    check(rx_hi == 1'b0 && rx_lo == 1'b0, "R9 loopback idle null", int'({rx_hi, rx_lo}), 0);

    // R6: start ignored right until busy falls, accepted the cycle after
    run_frame(16'h0080, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R5 back-to-back");
    check(busy == 1'b0, "R5 idle before restart", int'(busy), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(150000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R5 run did not finish actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule